// File: doc/BRIEF.md
# Asynchronous Character Framer with Echo

This block turns bytes from a host register file into asynchronous serial characters on `txd`, and turns characters arriving on `rxd` back into bytes for the host. All bit timing runs from a single-cycle `tick` enable that pulses at sixteen times the bit rate. The character format comes from a few static fields: word length (5 to 8 bits), parity enable and parity kind (odd, even, fixed one, fixed zero), and a long-stop selector. Two bits of transmit control switch the transmitter off, on, or into a continuous break.

The transmitter has a one-byte holding register that the host fills with `tx_load`. It moves the byte into its shifter only at a character boundary, and only while `cts_n` is low. So a change on the clear-to-send line never cuts a character short.

The receiver passes `rxd` through two synchroniser flops. It confirms a start bit at its midpoint and samples every later bit at its centre. It delivers the character, with parity and framing status, to a receive register that the host empties with `rx_read`. When echo is enabled, each received character is also loaded into the transmit holding register and sent back on `txd`.

The transmitter moves through six named states:
- `TX_IDLE` goes to `TX_BREAK` when a break is commanded, and to `TX_START` when a byte is held, the transmitter is on and CTS is asserted.
- `TX_START` goes to `TX_DATA`.
- `TX_DATA` goes to `TX_PAR` after the last data bit when parity is enabled, and to `TX_STOP` otherwise.
- `TX_PAR` goes to `TX_STOP`.
- `TX_STOP` returns to `TX_IDLE` when the stop period ends.
- `TX_BREAK` returns to `TX_IDLE` at the end of a bit once the break command is gone.

The receiver moves through five named states:
- `RX_IDLE` goes to `RX_START` when the synchronised line is low.
- `RX_START` returns to `RX_IDLE` when the line is high again at mid-bit (a false start). It goes to `RX_DATA` otherwise.
- `RX_DATA` goes to `RX_PAR` or `RX_STOP` after the last data bit.
- `RX_PAR` goes to `RX_STOP`.
- `RX_STOP` returns to `RX_IDLE` after sampling the stop bit.

Top module: `async_framer`

## Requirements
- R1: While reset is asserted, `txd` is 1, `tx_empty` is 1, and `rx_full`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: A character is a 0 start bit, then the data bits with the least significant bit first, then parity (if enabled), then stop bits at 1. Each bit lasts 16 ticks and the idle line is 1. `fmt_len` selects the data width: 00 is 8 bits, 01 is 7, 10 is 6 and 11 is 5.
- R3: With `par_en`=0 no parity bit is sent. With `par_en`=1, `par_sel` picks the parity bit: 00 makes the total number of ones odd, 01 makes it even, 10 sends a constant 1, and 11 sends a constant 0.
- R4: With `fmt_stop_long`=0 the stop period is 16 ticks. With `fmt_stop_long`=1 it is 32 ticks, except that it is 16 ticks for 8 data bits with parity and 24 ticks for 5 data bits without parity.
- R5: `tx_ctl`=11 (break) drives `txd` to 0 continuously, after any character in progress has finished. When the command is removed, `txd` returns to 1 at the end of the current 16-tick period.
- R6: `tx_ctl`=00 switches the transmitter off. A loaded byte stays held (`tx_empty`=0) and `txd` stays 1. The values 01 and 10 both switch the transmitter on.
- R7: While `cts_n` is 1, no new character starts. A character already under way is sent in full.
- R8: The receiver takes a start bit only if the line is still low at its midpoint. A shorter low pulse yields no character.
- R9: A received character appears right-aligned on `rx_data`, with `rx_full`=1. `rx_read` clears `rx_full`.
- R10: `err_parity` is set when a received parity bit disagrees with odd or even parity. It is never set in the constant-1 or constant-0 modes.
- R11: `err_frame` is set when the first stop bit is sampled low.
- R12: If a character completes while `rx_full` is 1, `err_overrun` is set and `rx_data` keeps the old byte. The next character that is accepted clears all three error flags to that character's own status.
- R13: With `echo_en`=1, each received character is transmitted on `txd` in the current format, even while `tx_ctl` is 00.
- R14: `tx_load` makes `tx_empty` 0 on the next cycle. `tx_empty` returns to 1 at the tick on which the held byte starts its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Single-cycle enable at sixteen times the bit rate |
| fmt_len | input | 2 | Data width code (00=8, 01=7, 10=6, 11=5) |
| fmt_stop_long | input | 1 | Selects the long stop period |
| par_en | input | 1 | Parity bit present |
| par_sel | input | 2 | Parity kind (00 odd, 01 even, 10 one, 11 zero) |
| echo_en | input | 1 | Retransmit received characters |
| tx_ctl | input | 2 | Transmitter control (00 off, 01/10 on, 11 break) |
| tx_load | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_read | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_full | output | 1 | Receive register holds an unread byte |
| err_parity | output | 1 | Parity error on the held byte |
| err_frame | output | 1 | Framing error on the held byte |
| err_overrun | output | 1 | A byte was lost while the register was full |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| cts_n | input | 1 | Clear to send, active low |

## Verification
The hardest situation to reach from the ports is a clear-to-send release in the middle of a character, because it has to land after the start bit has gone out and well before the stop bit. The bench drives `cts_n` high a fixed number of cycles after a held byte is released. A tick-accurate behavioural model then demands the full character followed by a held second byte. Break entry in the middle of a frame is reached the same way. Echo needs a received character to turn into an outgoing one, so the bench runs its serial driver and a serial decoder concurrently and compares the decoded byte with the byte it sent.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int FR_DATA_W = 8;

    typedef logic [3:0] bitcnt_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP,
        TX_BREAK
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    // Width code: 00 -> 8 bits, 11 -> 5 bits.
    function automatic bitcnt_t word_bits(input logic [1:0] len);
        return bitcnt_t'(4'd8 - {2'b00, len});
    endfunction

    // Stop period in ticks for a given format.
    function automatic int stop_span(input logic long_stop, input bitcnt_t n,
                                     input logic par, input int osr);
        if (!long_stop)               return osr;
        if (n == 4'd8 && par)         return osr;
        if (n == 4'd5 && !par)        return osr + osr / 2;
        return 2 * osr;
    endfunction

endpackage

// File: rtl/framer_tx.sv
module framer_tx
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [1:0]           fmt_len,
    input  logic                 fmt_stop_long,
    input  logic                 par_en,
    input  logic [1:0]           par_sel,
    input  logic                 tx_on,
    input  logic                 brk_cmd,
    input  logic                 cts_n,
    input  logic                 load,
    input  logic [FR_DATA_W-1:0] load_data,
    output logic                 hold_empty,
    output logic                 busy,
    output logic                 txd
);
    localparam int CW = $clog2(2 * OSR);

    tx_state_t            state, nxt;
    logic [CW-1:0]        cnt, stop_last;
    bitcnt_t              bidx, nbits_q, n_cur;
    logic [FR_DATA_W-1:0] hold, sh, d_cur;
    logic                 hold_full, par_q, pbit_q, pbit_cur;
    logic                 bit_end, last_bit, go;

    assign n_cur    = word_bits(fmt_len);
    assign d_cur    = hold & ({FR_DATA_W{1'b1}} >> (FR_DATA_W - int'(n_cur)));
    assign pbit_cur = par_sel[1] ? ~par_sel[0] : (par_sel[0] ? ^d_cur : ~^d_cur);
    assign bit_end  = (cnt == CW'(OSR - 1));
    assign last_bit = (bidx == nbits_q - 4'd1);
    assign go       = tick && (state == TX_IDLE) && !brk_cmd && hold_full && tx_on && !cts_n;

    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                TX_IDLE:  if (brk_cmd) nxt = TX_BREAK;
                          else if (go) nxt = TX_START;
                TX_START: if (bit_end) nxt = TX_DATA;
                TX_DATA:  if (bit_end && last_bit) nxt = par_q ? TX_PAR : TX_STOP;
                TX_PAR:   if (bit_end) nxt = TX_STOP;
                TX_STOP:  if (cnt == stop_last) nxt = TX_IDLE;
                TX_BREAK: if (bit_end && !brk_cmd) nxt = TX_IDLE;
                default:  nxt = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            stop_last <= '0;
            bidx      <= '0;
            nbits_q   <= '0;
            sh        <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            par_q     <= 1'b0;
            pbit_q    <= 1'b0;
        end else begin
            if (tick) begin
                if (state == TX_IDLE || state != nxt ||
                    (bit_end && (state == TX_DATA || state == TX_BREAK)))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
                if (go) begin
                    sh        <= hold;
                    nbits_q   <= n_cur;
                    par_q     <= par_en;
                    pbit_q    <= pbit_cur;
                    stop_last <= CW'(stop_span(fmt_stop_long, n_cur, par_en, OSR) - 1);
                    bidx      <= '0;
                end
                if (state == TX_DATA && bit_end) begin
                    sh   <= sh >> 1;
                    bidx <= bidx + 4'd1;
                end
            end
            if (go)   hold_full <= 1'b0;
            if (load) begin
                hold      <= load_data;
                hold_full <= 1'b1;
            end
        end
    end

    always_comb begin
        hold_empty = !hold_full;
        busy       = (state != TX_IDLE);
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit_q;
            TX_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/framer_rx.sv
module framer_rx
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic [1:0]           fmt_len,
    input  logic                 par_en,
    input  logic [1:0]           par_sel,
    output logic                 done,
    output logic [FR_DATA_W-1:0] char_out,
    output logic                 perr,
    output logic                 ferr
);
    localparam int CW = $clog2(2 * OSR);

    rx_state_t            state, nxt;
    logic [CW-1:0]        cnt;
    bitcnt_t              bidx, n_cur;
    logic [FR_DATA_W-1:0] sh, word;
    logic                 sync1, rxs, pbit, pexp, chk;
    logic                 bit_end, mid, last_bit;

    assign n_cur    = word_bits(fmt_len);
    assign bit_end  = (cnt == CW'(OSR - 1));
    assign mid      = (cnt == CW'(OSR / 2 - 1));
    assign last_bit = (bidx == n_cur - 4'd1);
    assign word     = sh >> (FR_DATA_W - int'(n_cur));
    assign pexp     = par_sel[0] ? ^word : ~^word;
    assign chk      = par_en && !par_sel[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rxs   <= 1'b1;
        end else begin
            sync1 <= rxd;
            rxs   <= sync1;
        end
    end

    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                RX_IDLE:  if (!rxs) nxt = RX_START;
                RX_START: if (mid) nxt = rxs ? RX_IDLE : RX_DATA;
                RX_DATA:  if (bit_end && last_bit) nxt = par_en ? RX_PAR : RX_STOP;
                RX_PAR:   if (bit_end) nxt = RX_STOP;
                RX_STOP:  if (bit_end) nxt = RX_IDLE;
                default:  nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bidx     <= '0;
            sh       <= '0;
            pbit     <= 1'b0;
            done     <= 1'b0;
            char_out <= '0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE || state != nxt || (state == RX_DATA && bit_end))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
                if (state == RX_START && nxt == RX_DATA) bidx <= '0;
                if (state == RX_DATA && bit_end) begin
                    sh   <= {rxs, sh[FR_DATA_W-1:1]};
                    bidx <= bidx + 4'd1;
                end
                if (state == RX_PAR && bit_end) pbit <= rxs;
                if (state == RX_STOP && bit_end) begin
                    done     <= 1'b1;
                    char_out <= word;
                    perr     <= chk && (pbit != pexp);
                    ferr     <= !rxs;
                end
            end
        end
    end

endmodule

// File: rtl/async_framer.sv
module async_framer
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fmt_len,
    input  logic       fmt_stop_long,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    input  logic       echo_en,
    input  logic [1:0] tx_ctl,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       tx_empty,
    input  logic       rx_read,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n
);
    logic                 tx_on, brk_cmd, tx_busy, hold_load;
    logic [FR_DATA_W-1:0] hold_data, rx_char;
    logic                 rx_done, rx_perr, rx_ferr;

    assign tx_on     = (tx_ctl != 2'b00) || echo_en;
    assign brk_cmd   = (tx_ctl == 2'b11) && !echo_en;
    assign hold_load = tx_load || (echo_en && rx_done);
    assign hold_data = (echo_en && rx_done) ? rx_char : tx_data;

    framer_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .fmt_len(fmt_len), .fmt_stop_long(fmt_stop_long),
        .par_en(par_en), .par_sel(par_sel),
        .tx_on(tx_on), .brk_cmd(brk_cmd), .cts_n(cts_n),
        .load(hold_load), .load_data(hold_data),
        .hold_empty(tx_empty), .busy(tx_busy), .txd(txd)
    );

    framer_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .fmt_len(fmt_len), .par_en(par_en), .par_sel(par_sel),
        .done(rx_done), .char_out(rx_char), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_full     <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (rx_read) rx_full <= 1'b0;
            if (rx_done) begin
                if (rx_full && !rx_read) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data     <= rx_char;
                    rx_full     <= 1'b1;
                    err_parity  <= rx_perr;
                    err_frame   <= rx_ferr;
                    err_overrun <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/framer_checker.sv
module framer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_load,
    input logic       tx_empty,
    input logic       rx_read,
    input logic       rx_done,
    input logic       rx_full,
    input logic [7:0] rx_data,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       cts_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       brk_cmd
);
    // R14: a host write leaves the holding register occupied.
    p_empty_after_load_r14: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_empty);

    // R9: a read with no simultaneous arrival empties the receive register.
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !rx_done) |=> !rx_full);

    // R12: the overrun flag rises without disturbing the held byte.
    p_overrun_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $stable(rx_data));

    // R10: the parity flag only rises on a character completion.
    p_parity_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> $past(rx_done));

    // R7: an idle transmitter never starts while clear-to-send is withdrawn.
    p_cts_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && cts_n && !brk_cmd) |=> txd);
endmodule

bind async_framer framer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_empty(tx_empty),
    .rx_read(rx_read), .rx_done(rx_done), .rx_full(rx_full), .rx_data(rx_data),
    .err_parity(err_parity), .err_overrun(err_overrun), .cts_n(cts_n),
    .txd(txd), .tx_busy(tx_busy), .brk_cmd(brk_cmd)
);

// File: tb/async_framer_test.sv
module async_framer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] fmt_len = 2'b00;
    logic       fmt_stop_long = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       echo_en = 1'b0;
    logic [1:0] tx_ctl = 2'b01;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_read = 1'b0;
    logic       rxd = 1'b1;
    logic       cts_n = 1'b0;
    logic       tx_empty, rx_full, err_parity, err_frame, err_overrun, txd;
    logic [7:0] rx_data;

    int    vec = 0;
    int    err = 0;
    bit    done_flag = 0;
    bit    cmp_en = 0;
    string cur = "R2";

    async_framer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_len(fmt_len),
        .fmt_stop_long(fmt_stop_long), .par_en(par_en), .par_sel(par_sel),
        .echo_en(echo_en), .tx_ctl(tx_ctl), .tx_load(tx_load), .tx_data(tx_data),
        .tx_empty(tx_empty), .rx_read(rx_read), .rx_data(rx_data), .rx_full(rx_full),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .rxd(rxd), .txd(txd), .cts_n(cts_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    // Behavioural reference of the transmit line: a queue of per-tick levels.
    bit   q[$];
    bit   m_hold = 0;
    bit   m_brk = 0;
    bit   m_lvl = 1;
    logic [7:0] m_data = 8'h00;

    task automatic push_n(bit v, int n);
        for (int i = 0; i < n; i++) q.push_back(v);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_hold = 0;
            m_brk = 0;
            m_lvl = 1;
        end else begin
            if (tick) begin
                if (q.size() == 0) begin
                    bit brk;
                    brk = (tx_ctl == 2'b11) && !echo_en;
                    if (m_brk) begin
                        if (brk) push_n(0, 16);
                        else begin m_brk = 0; q.push_back(1); end
                    end else if (brk) begin
                        m_brk = 1;
                        push_n(0, 16);
                    end else if (m_hold && (tx_ctl != 2'b00 || echo_en) && !cts_n) begin
                        int   n, st;
                        logic [7:0] dm;
                        bit   pb;
                        n  = 8 - fmt_len;
                        dm = m_data & ((8'd1 << n) - 8'd1);
                        if (n == 8) dm = m_data;
                        case (par_sel)
                            2'b00: pb = ~^dm;
                            2'b01: pb = ^dm;
                            2'b10: pb = 1;
                            default: pb = 0;
                        endcase
                        if (!fmt_stop_long) st = 16;
                        else if (n == 8 && par_en) st = 16;
                        else if (n == 5 && !par_en) st = 24;
                        else st = 32;
                        push_n(0, 16);
                        for (int i = 0; i < n; i++) push_n(dm[i], 16);
                        if (par_en) push_n(pb, 16);
                        push_n(1, st);
                        q.push_back(1);
                        m_hold = 0;
                    end
                end
                if (q.size() > 0) m_lvl = q.pop_front();
                else m_lvl = 1;
            end
            if (tx_load) begin
                m_hold = 1;
                m_data = tx_data;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en && !done_flag) begin
            vec++;
            if (txd !== m_lvl || tx_empty !== !m_hold) begin
                err++;
                $display("FAIL %s txd,tx_empty act=%b%b exp=%b%b", cur, txd, tx_empty, m_lvl, !m_hold);
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        err++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load_tx(logic [7:0] d);
        tx_data = d;
        tx_load = 1;
        @(negedge clk);
        tx_load = 0;
    endtask

    task automatic read_rx();
        rx_read = 1;
        @(negedge clk);
        rx_read = 0;
    endtask

    // One serial bit is 16 ticks = 32 clocks.
    task automatic send_rx(logic [7:0] d, int n, bit pen, bit pb, bit stop_ok);
        rxd = 0; wclk(32);
        for (int i = 0; i < n; i++) begin rxd = d[i]; wclk(32); end
        if (pen) begin rxd = pb; wclk(32); end
        if (stop_ok) begin rxd = 1; wclk(32); end
        else begin rxd = 0; wclk(24); rxd = 1; wclk(8); end
        wclk(64);
    endtask

    task automatic decode_tx(output logic [7:0] d);
        int k;
        d = 8'h00;
        k = 0;
        while (txd !== 1'b0 && k < 3000) begin @(negedge clk); k++; end
        wclk(16);
        check("R13 echo start bit", {7'd0, txd}, 8'h00);
        for (int i = 0; i < 8; i++) begin wclk(32); d[i] = txd; end
        wclk(32);
        check("R13 echo stop bit", {7'd0, txd}, 8'h01);
    endtask

    initial begin
        logic [7:0] got;
        wclk(4);
        check("R1 txd", {7'd0, txd}, 8'h01);
        check("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
        check("R1 rx flags", {4'd0, rx_full, err_parity, err_frame, err_overrun}, 8'h00);
        rst_n = 1;
        wclk(4);
        cmp_en = 1;

        // Transmit formats, compared on every clock against the model.
        cur = "R2 8N1";     load_tx(8'hA5); wclk(450);
        cur = "R2 5N1";     fmt_len = 2'b11; load_tx(8'h13); wclk(450);
        cur = "R3 odd 7b long R4"; fmt_len = 2'b01; par_en = 1; par_sel = 2'b00; fmt_stop_long = 1;
        load_tx(8'h55); wclk(450);
        cur = "R3 even 6b"; fmt_len = 2'b10; par_sel = 2'b01; load_tx(8'h2B); wclk(450);
        cur = "R3 mark 8b R4 single stop"; fmt_len = 2'b00; par_sel = 2'b10; load_tx(8'hF0); wclk(450);
        cur = "R3 space 8b"; par_sel = 2'b11; load_tx(8'h0F); wclk(450);
        cur = "R4 5b long 1.5 stop"; fmt_len = 2'b11; par_en = 0; load_tx(8'h1A); wclk(450);
        cur = "R14 back to back"; fmt_len = 2'b00; fmt_stop_long = 0;
        load_tx(8'h81); wclk(20); load_tx(8'h7E); wclk(900);

        // Transmitter off.
        cur = "R6"; tx_ctl = 2'b00; load_tx(8'h77); wclk(300);
        check("R6 held byte stays", {7'd0, tx_empty}, 8'h00);
        check("R6 line idle", {7'd0, txd}, 8'h01);
        tx_ctl = 2'b10; wclk(450);

        // Clear-to-send gating.
        cur = "R7"; tx_ctl = 2'b01; cts_n = 1; load_tx(8'h3C); wclk(300);
        check("R7 no start while cts_n high", {7'd0, tx_empty}, 8'h00);
        cts_n = 0; wclk(20); cts_n = 1; load_tx(8'hC3); wclk(450);
        check("R7 second byte held", {7'd0, tx_empty}, 8'h00);
        check("R7 frame completed", {7'd0, txd}, 8'h01);
        cts_n = 0; wclk(450);

        // Break.
        cur = "R5"; tx_ctl = 2'b11; wclk(100);
        check("R5 break low", {7'd0, txd}, 8'h00);
        tx_ctl = 2'b01; wclk(100);
        load_tx(8'hE7); wclk(40); tx_ctl = 2'b11; wclk(500);
        check("R5 break after frame", {7'd0, txd}, 8'h00);
        tx_ctl = 2'b01; wclk(100);
        check("R5 break released", {7'd0, txd}, 8'h01);

        // Receiver.
        send_rx(8'hC3, 8, 0, 0, 1);
        check("R9 rx_full", {7'd0, rx_full}, 8'h01);
        check("R9 rx_data", rx_data, 8'hC3);
        check("R9 no errors", {5'd0, err_parity, err_frame, err_overrun}, 8'h00);
        read_rx(); wclk(2);
        check("R9 read clears", {7'd0, rx_full}, 8'h00);

        rxd = 0; wclk(6); rxd = 1; wclk(300);
        check("R8 false start ignored", {7'd0, rx_full}, 8'h00);

        fmt_len = 2'b01; par_en = 1; par_sel = 2'b00;
        send_rx(8'h2A, 7, 1, 0, 1);
        check("R10 odd parity good", {6'd0, rx_full, err_parity}, 8'h02);
        check("R2 7-bit right aligned", rx_data, 8'h2A);
        read_rx();
        send_rx(8'h2A, 7, 1, 1, 1);
        check("R10 odd parity bad", {6'd0, rx_full, err_parity}, 8'h03);
        read_rx();
        fmt_len = 2'b00; par_sel = 2'b10;
        send_rx(8'hF0, 8, 1, 0, 1);
        check("R10 mark not checked", {6'd0, rx_full, err_parity}, 8'h02);
        read_rx();
        par_en = 0;

        send_rx(8'h5C, 8, 0, 0, 0);
        check("R11 framing error", {6'd0, rx_full, err_frame}, 8'h03);
        check("R11 data kept", rx_data, 8'h5C);
        read_rx();

        send_rx(8'h11, 8, 0, 0, 1);
        send_rx(8'h22, 8, 0, 0, 1);
        check("R12 overrun flag", {7'd0, err_overrun}, 8'h01);
        check("R12 old data kept", rx_data, 8'h11);
        read_rx();
        send_rx(8'h33, 8, 0, 0, 1);
        check("R12 next char clears", {5'd0, err_overrun, err_frame, err_parity}, 8'h00);
        check("R12 next char data", rx_data, 8'h33);
        read_rx();

        // Echo loopback.
        cmp_en = 0; cur = "R13"; echo_en = 1; tx_ctl = 2'b00;
        fork
            send_rx(8'h96, 8, 0, 0, 1);
            decode_tx(got);
        join
        check("R13 echoed byte", got, 8'h96);
        wclk(600);
        check("R13 byte also received", rx_data, 8'h96);
        read_rx();
        echo_en = 0; tx_ctl = 2'b01; wclk(10);
        cmp_en = 1; cur = "R14 after echo";
        load_tx(8'h42); wclk(450);

        finish_run();
    end
endmodule